// File: doc/BRIEF.md
# CAN Message Object Status Updater

This block holds the live state of one CAN message object as both the host processor and the bus engine see it. It keeps the flags for the send request, the transfer status, the remote send request, access rights and extended identifier format. It also holds the object's data length code, two interrupt enables and a 16-bit time stamp. The host changes the flags through a byte-wide register write port. The bus engine reports events as single-cycle strobes: start of frame, transmission done, remote frame received, and data frame received together with its length code.

The send request and transfer status flags have two writers. The host raises a send request and the bus engine drops it once the frame has gone out. The bus engine raises the transfer status and the host acknowledges it. At every start of frame the block samples an external free-running counter into a holding register. The held value becomes the object's time stamp only when that frame completes without error. The block derives a clamped transmit byte count and the identifier width from the stored settings, and it produces one-cycle transmit and receive interrupt pulses.

Top module: `can_mobj_status`

## Requirements
- R1: A host write to the control register (select 0) with bit 0 set raises the send request on the next cycle. With bit 0 clear, the write leaves the send request unchanged.
- R2: A transmission-done strobe clears the send request. When a host set arrives in the same cycle, the host set wins and the request stays raised.
- R3: A transmission-done or data-received strobe sets the transfer status. A control write with bit 1 clear clears it, and a control write with bit 1 set leaves it unchanged. A bus set wins over a host clear in the same cycle.
- R4: A remote-frame strobe sets the remote send request and a transmission-done strobe clears it; a control write loads it from bit 2. A remote strobe wins over a transmission-done strobe in the same cycle.
- R5: A start-of-frame strobe samples the free-running counter into a holding register. The time stamp output takes the held value only on a transmission-done or data-received strobe, and it otherwise keeps its value. If a start of frame coincides with a commit, the value held before that cycle is committed. The output is little-endian: bits 7:0 are the low byte.
- R6: A data-received strobe stores the received 4-bit length code unchanged, including values 9 to 15. It takes priority over a host write in the same cycle.
- R7: The transmit byte count equals the stored length code when that code is at most 8, and equals 8 otherwise. The length code output itself stays unchanged.
- R8: A config write (select 1) loads bit 0 as the extended-format flag, bit 1 as the transmit interrupt enable, bit 2 as the receive interrupt enable and bits 7:4 as the length code. The identifier width output reads 29 when the extended-format flag is set and 11 when it is clear.
- R9: A transmission-done strobe with the transmit enable set gives a one-cycle transmit interrupt in the next cycle. A data-received strobe with the receive enable set does the same on the receive interrupt. Each enable gates only its own interrupt.
- R10: After reset all flags, enables, the length code, the time stamp and both interrupts read 0, and the identifier width reads 11. The access flag follows bit 3 of control writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_wr_en | input | 1 | Host register write strobe |
| cpu_wr_sel | input | 1 | Register select: 0 control, 1 config |
| cpu_wr_data | input | 8 | Host write data |
| bus_sof | input | 1 | Start-of-frame strobe |
| bus_tx_ok | input | 1 | Successful transmission strobe |
| bus_rx_remote | input | 1 | Matching remote frame received strobe |
| bus_rx_data | input | 1 | Data frame received strobe |
| bus_rx_dlc | input | 4 | Length code of the received data frame |
| free_cnt | input | 16 | Free-running counter value |
| send_req | output | 1 | Send request flag |
| xfer_done | output | 1 | Transfer status flag |
| remote_req | output | 1 | Remote send request flag |
| cpu_access | output | 1 | Host access flag |
| ext_fmt | output | 1 | Extended identifier format flag |
| id_width | output | 5 | Identifier width in bits, 11 or 29 |
| dlc | output | 4 | Stored length code |
| tx_bytes | output | 4 | Number of data bytes to send, clamped to 8 |
| stamp_bytes | output | 16 | Time stamp, low byte in bits 7:0 |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
Every piece of state drives a port directly, so a wrong flag update is visible on the cycle after the strobe that caused it. A wrong holding register is subtler. It stays hidden until the next commit and then appears as the wrong time stamp. For that reason the checks split the capture and the commit across separate cycles and also place them in the same cycle. Priority errors between the two writers appear only when both act in the same cycle, so each contested flag gets a test with simultaneous writes.

// File: rtl/can_mobj_pkg.sv
package can_mobj_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [0:0] {
    SEL_CTRL = 1'b0,
    SEL_CFG  = 1'b1
  } reg_sel_e;

  // Control register bit positions
  localparam int CTRL_SR_BIT  = 0;
  localparam int CTRL_TS_BIT  = 1;
  localparam int CTRL_RSR_BIT = 2;
  localparam int CTRL_ACC_BIT = 3;

  // Config register bit positions
  localparam int CFG_EXT_BIT = 0;
  localparam int CFG_TIE_BIT = 1;
  localparam int CFG_RIE_BIT = 2;
  localparam int CFG_DLC_LSB = 4;

  typedef struct packed {
    logic sof;
    logic tx_ok;
    logic rx_remote;
    logic rx_data;
  } bus_evt_t;

endpackage

// File: rtl/can_mobj_flags.sv
module can_mobj_flags
  import can_mobj_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  bus_evt_t         evt,
  output logic             send_req,
  output logic             xfer_done,
  output logic             remote_req,
  output logic             cpu_access
);

  logic sr_q, sr_d, sr_en;
  logic ts_q, ts_d, ts_en;
  logic rsr_q, rsr_d, rsr_en;
  logic acc_q, acc_d, acc_en;
  logic host_sr_set, host_ts_clr, bus_commit;

  assign host_sr_set = ctrl_wr & wdata[CTRL_SR_BIT];
  assign host_ts_clr = ctrl_wr & ~wdata[CTRL_TS_BIT];
  assign bus_commit  = evt.tx_ok | evt.rx_data;

  // Next-state logic
  always_comb begin
    sr_d  = sr_q;
    sr_en = 1'b0;
    if (host_sr_set) begin
      sr_d  = 1'b1;
      sr_en = 1'b1;
    end else if (evt.tx_ok) begin
      sr_d  = 1'b0;
      sr_en = 1'b1;
    end

    ts_d  = ts_q;
    ts_en = 1'b0;
    if (bus_commit) begin
      ts_d  = 1'b1;
      ts_en = 1'b1;
    end else if (host_ts_clr) begin
      ts_d  = 1'b0;
      ts_en = 1'b1;
    end

    rsr_d  = rsr_q;
    rsr_en = 1'b0;
    if (evt.rx_remote) begin
      rsr_d  = 1'b1;
      rsr_en = 1'b1;
    end else if (evt.tx_ok) begin
      rsr_d  = 1'b0;
      rsr_en = 1'b1;
    end else if (ctrl_wr) begin
      rsr_d  = wdata[CTRL_RSR_BIT];
      rsr_en = 1'b1;
    end

    acc_en = ctrl_wr;
    acc_d  = wdata[CTRL_ACC_BIT];
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= 1'b0;
      ts_q  <= 1'b0;
      rsr_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      if (sr_en)  sr_q  <= sr_d;
      if (ts_en)  ts_q  <= ts_d;
      if (rsr_en) rsr_q <= rsr_d;
      if (acc_en) acc_q <= acc_d;
    end
  end

  assign send_req   = sr_q;
  assign xfer_done  = ts_q;
  assign remote_req = rsr_q;
  assign cpu_access = acc_q;

  assert_sr_host_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && wdata[CTRL_SR_BIT]) |=> send_req);

  assert_sr_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt.tx_ok && !(ctrl_wr && wdata[CTRL_SR_BIT])) |=> $stable(send_req));

  assert_sr_bus_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.tx_ok && !(ctrl_wr && wdata[CTRL_SR_BIT])) |=> !send_req);

  assert_ts_bus_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.tx_ok || evt.rx_data) |=> xfer_done);

  assert_rsr_remote_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rx_remote |=> remote_req);

  assert_rsr_sent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.tx_ok && !evt.rx_remote) |=> !remote_req);

endmodule

// File: rtl/can_mobj_cfg.sv
module can_mobj_cfg
  import can_mobj_pkg::*;
#(
  parameter int DLC_W        = 4,
  parameter int MAX_TX_BYTES = 8,
  parameter int STD_ID_W     = 11,
  parameter int EXT_ID_W     = 29,
  localparam int IDW_W       = $clog2(EXT_ID_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rx_data,
  input  logic [DLC_W-1:0]  rx_dlc,
  output logic              ext_fmt,
  output logic              tx_ie,
  output logic              rx_ie,
  output logic [DLC_W-1:0]  dlc,
  output logic [DLC_W-1:0]  tx_bytes,
  output logic [IDW_W-1:0]  id_width
);

  localparam logic [DLC_W-1:0] MAX_BYTES_L = DLC_W'(MAX_TX_BYTES);
  localparam logic [IDW_W-1:0] STD_W_L     = IDW_W'(STD_ID_W);
  localparam logic [IDW_W-1:0] EXT_W_L     = IDW_W'(EXT_ID_W);

  logic             ext_q, tie_q, rie_q;
  logic             ext_d, tie_d, rie_d, opt_en;
  logic [DLC_W-1:0] dlc_q, dlc_d;
  logic             dlc_en;

  // Next-state logic
  always_comb begin
    opt_en = cfg_wr;
    ext_d  = wdata[CFG_EXT_BIT];
    tie_d  = wdata[CFG_TIE_BIT];
    rie_d  = wdata[CFG_RIE_BIT];

    dlc_d  = dlc_q;
    dlc_en = 1'b0;
    if (rx_data) begin
      dlc_d  = rx_dlc;
      dlc_en = 1'b1;
    end else if (cfg_wr) begin
      dlc_d  = wdata[CFG_DLC_LSB +: DLC_W];
      dlc_en = 1'b1;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q <= 1'b0;
      tie_q <= 1'b0;
      rie_q <= 1'b0;
      dlc_q <= '0;
    end else begin
      if (opt_en) begin
        ext_q <= ext_d;
        tie_q <= tie_d;
        rie_q <= rie_d;
      end
      if (dlc_en) dlc_q <= dlc_d;
    end
  end

  // Derived views
  always_comb begin
    tx_bytes = (dlc_q > MAX_BYTES_L) ? MAX_BYTES_L : dlc_q;
    id_width = ext_q ? EXT_W_L : STD_W_L;
  end

  assign ext_fmt = ext_q;
  assign tx_ie   = tie_q;
  assign rx_ie   = rie_q;
  assign dlc     = dlc_q;

  assert_rx_dlc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_data |=> (dlc == $past(rx_dlc)));

  assert_tx_bytes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_bytes <= MAX_BYTES_L) && (tx_bytes <= dlc));

  assert_id_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !rx_data) |=> (id_width == ($past(wdata[CFG_EXT_BIT]) ? EXT_W_L : STD_W_L)));

endmodule

// File: rtl/can_mobj_stamp.sv
module can_mobj_stamp
  import can_mobj_pkg::*;
#(
  parameter int TS_W   = 16,
  localparam int NBYTES = TS_W / BYTE_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sof,
  input  logic            commit,
  input  logic [TS_W-1:0] cnt_in,
  output logic [TS_W-1:0] stamp_bytes
);

  logic [TS_W-1:0] hold_q, hold_d;
  logic            hold_en;
  logic [TS_W-1:0] stamp_q;

  // Next-state logic for the holding register
  always_comb begin
    hold_en = sof;
    hold_d  = cnt_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (hold_en) begin
      hold_q <= hold_d;
    end
  end

  // One byte lane per stamp byte, lane 0 holds the low byte
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] lane_d;
    logic              lane_en;

    always_comb begin
      lane_en = commit;
      lane_d  = hold_q[b*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stamp_q[b*BYTE_W +: BYTE_W] <= '0;
      end else if (lane_en) begin
        stamp_q[b*BYTE_W +: BYTE_W] <= lane_d;
      end
    end
  end

  assign stamp_bytes = stamp_q;

  assert_stamp_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(stamp_bytes));

  assert_stamp_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (stamp_bytes == $past(hold_q)));

  assert_hold_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> (hold_q == $past(cnt_in)));

endmodule

// File: rtl/can_mobj_irq.sv
module can_mobj_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_ok,
  input  logic rx_data,
  input  logic tx_ie,
  input  logic rx_ie,
  output logic tx_irq,
  output logic rx_irq
);

  logic tx_q, tx_d, rx_q, rx_d;

  always_comb begin
    tx_d = tx_ok & tx_ie;
    rx_d = rx_data & rx_ie;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q <= 1'b0;
      rx_q <= 1'b0;
    end else begin
      tx_q <= tx_d;
      rx_q <= rx_d;
    end
  end

  assign tx_irq = tx_q;
  assign rx_irq = rx_q;

  assert_tx_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> $past(tx_ok && tx_ie));

  assert_rx_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(rx_data && rx_ie));

endmodule

// File: rtl/can_mobj_status.sv
module can_mobj_status
  import can_mobj_pkg::*;
#(
  parameter int DLC_W        = 4,
  parameter int TS_W         = 16,
  parameter int MAX_TX_BYTES = 8,
  parameter int STD_ID_W     = 11,
  parameter int EXT_ID_W     = 29,
  localparam int IDW_W       = $clog2(EXT_ID_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr_en,
  input  logic              cpu_wr_sel,
  input  logic [7:0]        cpu_wr_data,
  input  logic              bus_sof,
  input  logic              bus_tx_ok,
  input  logic              bus_rx_remote,
  input  logic              bus_rx_data,
  input  logic [DLC_W-1:0]  bus_rx_dlc,
  input  logic [TS_W-1:0]   free_cnt,
  output logic              send_req,
  output logic              xfer_done,
  output logic              remote_req,
  output logic              cpu_access,
  output logic              ext_fmt,
  output logic [IDW_W-1:0]  id_width,
  output logic [DLC_W-1:0]  dlc,
  output logic [DLC_W-1:0]  tx_bytes,
  output logic [TS_W-1:0]   stamp_bytes,
  output logic              tx_irq,
  output logic              rx_irq
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // Write decode and event bundling
  logic     ctrl_wr, cfg_wr;
  bus_evt_t evt;
  logic     tie, rie;

  always_comb begin
    ctrl_wr       = cpu_wr_en & (reg_sel_e'(cpu_wr_sel) == SEL_CTRL);
    cfg_wr        = cpu_wr_en & (reg_sel_e'(cpu_wr_sel) == SEL_CFG);
    evt.sof       = bus_sof;
    evt.tx_ok     = bus_tx_ok;
    evt.rx_remote = bus_rx_remote;
    evt.rx_data   = bus_rx_data;
  end

  can_mobj_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .ctrl_wr    (ctrl_wr),
    .wdata      (cpu_wr_data),
    .evt        (evt),
    .send_req   (send_req),
    .xfer_done  (xfer_done),
    .remote_req (remote_req),
    .cpu_access (cpu_access)
  );

  can_mobj_cfg #(
    .DLC_W        (DLC_W),
    .MAX_TX_BYTES (MAX_TX_BYTES),
    .STD_ID_W     (STD_ID_W),
    .EXT_ID_W     (EXT_ID_W)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cfg_wr   (cfg_wr),
    .wdata    (cpu_wr_data),
    .rx_data  (bus_rx_data),
    .rx_dlc   (bus_rx_dlc),
    .ext_fmt  (ext_fmt),
    .tx_ie    (tie),
    .rx_ie    (rie),
    .dlc      (dlc),
    .tx_bytes (tx_bytes),
    .id_width (id_width)
  );

  can_mobj_stamp #(
    .TS_W (TS_W)
  ) u_stamp (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sof         (bus_sof),
    .commit      (bus_tx_ok | bus_rx_data),
    .cnt_in      (free_cnt),
    .stamp_bytes (stamp_bytes)
  );

  can_mobj_irq u_irq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tx_ok   (bus_tx_ok),
    .rx_data (bus_rx_data),
    .tx_ie   (tie),
    .rx_ie   (rie),
    .tx_irq  (tx_irq),
    .rx_irq  (rx_irq)
  );

  assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) |-> (!send_req && !xfer_done && !remote_req && !tx_irq && !rx_irq));

endmodule

// File: tb/can_mobj_status_tb.sv
module can_mobj_status_tb;

  logic        clk;
  logic        rst_n;
  logic        cpu_wr_en;
  logic        cpu_wr_sel;
  logic [7:0]  cpu_wr_data;
  logic        bus_sof, bus_tx_ok, bus_rx_remote, bus_rx_data;
  logic [3:0]  bus_rx_dlc;
  logic [15:0] free_cnt;
  logic        send_req, xfer_done, remote_req, cpu_access, ext_fmt;
  logic [4:0]  id_width;
  logic [3:0]  dlc, tx_bytes;
  logic [15:0] stamp_bytes;
  logic        tx_irq, rx_irq;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  can_mobj_status u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_wr_en     (cpu_wr_en),
    .cpu_wr_sel    (cpu_wr_sel),
    .cpu_wr_data   (cpu_wr_data),
    .bus_sof       (bus_sof),
    .bus_tx_ok     (bus_tx_ok),
    .bus_rx_remote (bus_rx_remote),
    .bus_rx_data   (bus_rx_data),
    .bus_rx_dlc    (bus_rx_dlc),
    .free_cnt      (free_cnt),
    .send_req      (send_req),
    .xfer_done     (xfer_done),
    .remote_req    (remote_req),
    .cpu_access    (cpu_access),
    .ext_fmt       (ext_fmt),
    .id_width      (id_width),
    .dlc           (dlc),
    .tx_bytes      (tx_bytes),
    .stamp_bytes   (stamp_bytes),
    .tx_irq        (tx_irq),
    .rx_irq        (rx_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  // One cycle of stimulus, applied at a falling edge; returns at the next
  // falling edge, after the registers have taken the stimulus.
  task automatic step(input logic wr, input logic sel, input logic [7:0] data,
                      input logic sof, input logic tx, input logic rem, input logic rxd);
    @(negedge clk);
    cpu_wr_en     = wr;
    cpu_wr_sel    = sel;
    cpu_wr_data   = data;
    bus_sof       = sof;
    bus_tx_ok     = tx;
    bus_rx_remote = rem;
    bus_rx_data   = rxd;
    @(negedge clk);
    cpu_wr_en     = 1'b0;
    bus_sof       = 1'b0;
    bus_tx_ok     = 1'b0;
    bus_rx_remote = 1'b0;
    bus_rx_data   = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cpu_wr_en = 1'b0; cpu_wr_sel = 1'b0; cpu_wr_data = 8'h00;
    bus_sof = 1'b0; bus_tx_ok = 1'b0; bus_rx_remote = 1'b0; bus_rx_data = 1'b0;
    bus_rx_dlc = 4'h0; free_cnt = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10", "send_req",  send_req,    0);
    chk("R10", "xfer_done", xfer_done,   0);
    chk("R10", "remote",    remote_req,  0);
    chk("R10", "access",    cpu_access,  0);
    chk("R10", "dlc",       dlc,         0);
    chk("R10", "stamp",     stamp_bytes, 0);
    chk("R10", "irqs",      {tx_irq, rx_irq}, 0);
    chk("R10", "id_width",  id_width,    11);
  endtask

  task automatic t_send_req();
    step(1, 0, 8'h01, 0, 0, 0, 0);
    chk("R1", "set by host", send_req, 1);
    step(1, 0, 8'h08, 0, 0, 0, 0);
    chk("R1", "zero write keeps", send_req, 1);
    chk("R10", "access bit3", cpu_access, 1);
    step(0, 0, 8'h00, 0, 1, 0, 0);
    chk("R2", "bus clear", send_req, 0);
    step(1, 0, 8'h01, 0, 0, 0, 0);
    step(1, 0, 8'h01, 0, 1, 0, 0);
    chk("R2", "host set wins", send_req, 1);
    step(0, 0, 8'h00, 0, 1, 0, 0);
    chk("R2", "cleared after race", send_req, 0);
  endtask

  task automatic t_xfer_done();
    step(1, 0, 8'h00, 0, 0, 0, 0);
    chk("R3", "host clear", xfer_done, 0);
    step(0, 0, 8'h00, 0, 0, 0, 1);
    chk("R3", "set by rx", xfer_done, 1);
    step(1, 0, 8'h02, 0, 0, 0, 0);
    chk("R3", "write one keeps", xfer_done, 1);
    step(1, 0, 8'h00, 0, 0, 0, 0);
    chk("R3", "write zero clears", xfer_done, 0);
    step(1, 0, 8'h00, 0, 1, 0, 0);
    chk("R3", "bus set wins", xfer_done, 1);
  endtask

  task automatic t_remote();
    step(0, 0, 8'h00, 0, 0, 1, 0);
    chk("R4", "remote set", remote_req, 1);
    step(0, 0, 8'h00, 0, 0, 0, 1);
    chk("R4", "rx data keeps", remote_req, 1);
    step(0, 0, 8'h00, 0, 1, 0, 0);
    chk("R4", "cleared by tx", remote_req, 0);
    step(0, 0, 8'h00, 0, 1, 1, 0);
    chk("R4", "remote wins", remote_req, 1);
    step(1, 0, 8'h00, 0, 0, 0, 0);
    chk("R4", "host load zero", remote_req, 0);
  endtask

  task automatic t_stamp();
    logic [15:0] base;
    base = stamp_bytes;
    free_cnt = 16'hA1B2;
    step(0, 0, 8'h00, 1, 0, 0, 0);
    free_cnt = 16'h1234;
    step(0, 0, 8'h00, 0, 0, 0, 0);
    chk("R5", "no commit without success", stamp_bytes, base);
    step(0, 0, 8'h00, 0, 1, 0, 0);
    chk("R5", "low byte", stamp_bytes[7:0], 8'hB2);
    chk("R5", "high byte", stamp_bytes[15:8], 8'hA1);
    free_cnt = 16'h1111;
    step(0, 0, 8'h00, 1, 0, 0, 0);
    free_cnt = 16'h2222;
    step(0, 0, 8'h00, 1, 0, 0, 1);
    chk("R5", "commit old hold on coincident sof", stamp_bytes, 16'h1111);
    step(0, 0, 8'h00, 0, 0, 0, 1);
    chk("R5", "commit new hold", stamp_bytes, 16'h2222);
  endtask

  task automatic t_dlc();
    bus_rx_dlc = 4'hC;
    step(0, 0, 8'h00, 0, 0, 0, 1);
    chk("R6", "rx dlc above 8", dlc, 4'hC);
    chk("R7", "clamped bytes", tx_bytes, 8);
    bus_rx_dlc = 4'h3;
    step(1, 1, 8'hF0, 0, 0, 0, 1);
    chk("R6", "rx wins over host", dlc, 4'h3);
    chk("R7", "small bytes", tx_bytes, 3);
    step(1, 1, 8'h80, 0, 0, 0, 0);
    chk("R7", "dlc eight", tx_bytes, 8);
    step(1, 1, 8'h90, 0, 0, 0, 0);
    chk("R7", "dlc nine kept", dlc, 9);
    chk("R7", "dlc nine bytes", tx_bytes, 8);
  endtask

  task automatic t_idw();
    step(1, 1, 8'h01, 0, 0, 0, 0);
    chk("R8", "extended flag", ext_fmt, 1);
    chk("R8", "width 29", id_width, 29);
    step(1, 1, 8'h00, 0, 0, 0, 0);
    chk("R8", "width 11", id_width, 11);
  endtask

  task automatic t_irq();
    step(1, 1, 8'h02, 0, 0, 0, 0);
    step(0, 0, 8'h00, 0, 1, 0, 0);
    chk("R9", "tx irq raised", tx_irq, 1);
    chk("R9", "rx irq quiet", rx_irq, 0);
    @(negedge clk);
    chk("R9", "tx irq one cycle", tx_irq, 0);
    step(0, 0, 8'h00, 0, 0, 0, 1);
    chk("R9", "rx gated off", rx_irq, 0);
    step(1, 1, 8'h04, 0, 0, 0, 0);
    step(0, 0, 8'h00, 0, 0, 0, 1);
    chk("R9", "rx irq raised", rx_irq, 1);
    step(0, 0, 8'h00, 0, 1, 0, 0);
    chk("R9", "tx gated off", tx_irq, 0);
    chk("R9", "rx irq dropped", rx_irq, 0);
  endtask

  initial begin
    t_reset();
    t_send_req();
    t_xfer_done();
    t_remote();
    t_stamp();
    t_dlc();
    t_idw();
    t_irq();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule